// File: doc/BRIEF.md
# Accumulator Processor with Operator Panel

A small processor with one 8-bit accumulator and a single 64-byte memory that holds instructions, data and the I/O location together. Every instruction fills one byte: the top two bits choose the operation and the low six bits name a memory address. Four operations exist: NOR into the accumulator, ADD into the accumulator with a carry flag, store the accumulator, and a conditional jump on a clear carry. Each instruction takes three clock cycles: fetch, decode and execute.

The top address, 0x3F, is not storage. A read there returns the input port, and a write there loads the output register. An operator panel can stop the sequencer at an instruction boundary. While stopped, the panel's address selects the memory location, a write strobe deposits the panel's data byte, and the selected byte is shown on a read-back port. Reset does not clear memory, so a program entered from the panel survives a reset and starts running at address 0.

Top module: `acc_cpu_panel`

## Requirements
- R1: Asynchronous active-low reset clears the program counter, accumulator, carry flag and output register, and leaves the sequencer at the fetch step. Memory contents are kept across reset.
- R2: Bits 7:6 of an instruction are the opcode and bits 5:0 are the operand address. Execution repeats fetch, decode and execute, three cycles per instruction. The program counter advances by one in the decode cycle, so after release of reset with the run input high it reads 0 after one clock edge and 1 after two.
- R3: Opcode 00 loads the accumulator with the bitwise NOR of the accumulator and the byte at the operand address.
- R4: Opcode 01 loads the accumulator with the low 8 bits of accumulator plus operand and sets the carry flag to bit 8 of that sum.
- R5: Opcode 10 writes the accumulator to the operand address. When the address is 0x3F, the byte goes to the output port instead of memory.
- R6: Opcode 11 with the carry clear loads the program counter with the operand address. With the carry set, it clears the carry and execution continues at the next address.
- R7: Any read of address 0x3F returns the input port. This covers operand reads, instruction fetch and panel read-back.
- R8: The program counter wraps from 63 to 0.
- R9: With the run input low, the sequencer stops at the next fetch step. While stopped, the program counter, accumulator and carry stay unchanged.
- R10: While stopped, a high panel write strobe writes the panel data byte to the panel address on the clock edge, and the read-back port shows the byte held at the panel address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High: execute; low: stop at the next fetch step |
| pnl_addr_i | input | 6 | Panel address used while stopped |
| pnl_data_i | input | 8 | Panel data to deposit |
| pnl_wr_i | input | 1 | Panel write strobe, used while stopped |
| in_port_i | input | 8 | Input port, read at address 0x3F |
| out_port_o | output | 8 | Output register, written at address 0x3F |
| rd_data_o | output | 8 | Byte at the selected address (panel address while stopped) |
| pc_o | output | 6 | Program counter |
| acc_o | output | 8 | Accumulator |
| carry_o | output | 1 | Carry flag |

## Verification
The bound checker looks at every cycle. It checks that the fetch, decode and execute steps follow each other in order, that the ADD result and carry equal the 9-bit sum of the previous accumulator and operand, that a taken-carry jump clears the carry, that a store to 0x3F loads the output register, that the counter wraps at 63, and that nothing moves while the panel holds the machine. The bench scenarios cover what the checker cannot see. They sweep operand pairs through NOR and ADD programs entered from the panel. They confirm memory contents and branch outcomes by panel read-back after the run. They cover the full deposit-and-examine pass over the address space, the input port as operand and as instruction, and the exact clock edge at which the counter wraps.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  typedef enum logic [1:0] {
    OP_NOR = 2'b00,
    OP_ADD = 2'b01,
    OP_STA = 2'b10,
    OP_JCC = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2
  } state_e;
endpackage

// File: rtl/pc_ctr.sv
module pc_ctr #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          load_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_o <= '0;
    else if (load_i) pc_o <= target_i;
    else if (inc_i)  pc_o <= pc_o + 1'b1;  // natural wrap
  end
endmodule

// File: rtl/nor_add_alu.sv
module nor_add_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          add_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  logic [DW:0] sum;

  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i};
    if (add_i) begin
      res_o  = sum[DW-1:0];
      cout_o = sum[DW];
    end else begin
      res_o  = ~(a_i | b_i);
      cout_o = 1'b0;
    end
  end
endmodule

// File: rtl/unified_mem.sv
module unified_mem #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic [DW-1:0] in_port_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] out_port_o
);
  localparam int          DEPTH   = 2 ** AW;
  localparam logic [AW-1:0] IO_ADDR = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic          io_sel;

  assign io_sel  = (addr_i == IO_ADDR);
  assign rdata_o = io_sel ? in_port_i : mem_q[addr_i];

  // storage keeps contents over reset
  always_ff @(posedge clk_i) begin
    if (we_i && !io_sel) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              out_port_o <= '0;
    else if (we_i && io_sel)  out_port_o <= wdata_i;
  end
endmodule

// File: rtl/acc_cpu_panel.sv
module acc_cpu_panel
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [AW-1:0] pnl_addr_i,
  input  logic [DW-1:0] pnl_data_i,
  input  logic          pnl_wr_i,
  input  logic [DW-1:0] in_port_i,
  output logic [DW-1:0] out_port_o,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic          carry_o
);
  localparam int OPW = DW - AW;

  state_e        state_q;
  op_e           op_q;
  logic [AW-1:0] ar_q;
  logic          halted;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] alu_res;
  logic          alu_cout;
  logic          exec;

  assign halted    = (state_q == ST_FETCH) && !run_i;
  assign exec      = (state_q == ST_EXEC);
  // panel takes over address and write data while stopped
  assign mem_addr  = halted ? pnl_addr_i : ar_q;
  assign mem_wdata = halted ? pnl_data_i : acc_o;
  assign mem_we    = halted ? pnl_wr_i : (exec && op_q == OP_STA);
  assign rd_data_o = rd_data;

  unified_mem #(.DW(DW), .AW(AW)) i_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (mem_addr),
    .wdata_i    (mem_wdata),
    .we_i       (mem_we),
    .in_port_i  (in_port_i),
    .rdata_o    (rd_data),
    .out_port_o (out_port_o)
  );

  nor_add_alu #(.DW(DW)) i_alu (
    .a_i    (acc_o),
    .b_i    (rd_data),
    .add_i  (op_q == OP_ADD),
    .res_o  (alu_res),
    .cout_o (alu_cout)
  );

  pc_ctr #(.AW(AW)) i_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (state_q == ST_DECODE),
    .load_i   (exec && op_q == OP_JCC && !carry_o),
    .target_i (ar_q),
    .pc_o     (pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      op_q    <= OP_NOR;
      ar_q    <= '0;
      acc_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_FETCH: if (run_i) begin
          ar_q    <= pc_o;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          op_q    <= op_e'(rd_data[DW-1 -: OPW]);
          ar_q    <= rd_data[AW-1:0];
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          unique case (op_q)
            OP_NOR: acc_o <= alu_res;
            OP_ADD: begin
              acc_o   <= alu_res;
              carry_o <= alu_cout;
            end
            OP_JCC:  if (carry_o) carry_o <= 1'b0;
            default: ;
          endcase
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic [1:0]    state_i,
  input logic [1:0]    op_i,
  input logic [AW-1:0] ar_i,
  input logic [DW-1:0] src_i,
  input logic [AW-1:0] pc_i,
  input logic [DW-1:0] acc_i,
  input logic          carry_i,
  input logic [DW-1:0] out_i
);
  localparam logic [AW-1:0] TOP = AW'((2 ** AW) - 1);

  logic is_exec;
  logic [DW:0] acc_ext, src_ext, res_ext;
  assign is_exec = (state_i == ST_EXEC);
  assign acc_ext = {1'b0, acc_i};
  assign src_ext = {1'b0, src_i};
  assign res_ext = {carry_i, acc_i};

  // R2
  step_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DECODE) |=> (state_i == ST_EXEC));
  // R2
  exec_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_exec |=> (state_i == ST_FETCH));
  // R4
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_exec && op_i == OP_ADD) |=> (res_ext == $past(acc_ext) + $past(src_ext)));
  // R5
  out_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_exec && op_i == OP_STA && ar_i == TOP) |=> (out_i == $past(acc_i)));
  // R6
  jcc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_exec && op_i == OP_JCC && carry_i) |=> !carry_i);
  // R8
  pc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DECODE && pc_i == TOP) |=> (pc_i == '0));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH && !run_i) |=> ($stable(pc_i) && $stable(acc_i) && $stable(carry_i)));
endmodule

bind acc_cpu_panel acc_cpu_chk #(.DW(DW), .AW(AW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .state_i (state_q),
  .op_i    (op_q),
  .ar_i    (ar_q),
  .src_i   (rd_data),
  .pc_i    (pc_o),
  .acc_i   (acc_o),
  .carry_i (carry_o),
  .out_i   (out_port_o)
);

// File: tb/test_acc_cpu_panel.sv
`timescale 1ns/1ps
module test_acc_cpu_panel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic [5:0] pnl_addr_i = '0;
  logic [7:0] pnl_data_i = '0;
  logic       pnl_wr_i = 1'b0;
  logic [7:0] in_port_i = '0;
  logic [7:0] out_port_o, rd_data_o, acc_o;
  logic [5:0] pc_o;
  logic       carry_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  acc_cpu_panel i_acc_cpu_panel (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i);
    pnl_addr_i = a; pnl_data_i = d; pnl_wr_i = 1'b1;
    @(negedge clk_i);
    pnl_wr_i = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk_i);
    pnl_addr_i = a;
    #1 d = rd_data_o;
  endtask

  task automatic do_reset();
    run_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run_prog(input int n);
    do_reset();
    run_i = 1'b1;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
    run_i = 1'b0;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    #1ms;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [8:0] s;
    logic [7:0] p0, p1;
    do_reset();
    // R1 reset state
    #1;
    chk("R1 pc", {2'b0, pc_o}, 8'h00);
    chk("R1 acc", acc_o, 8'h00);
    chk("R1 carry", {7'b0, carry_o}, 8'h00);
    chk("R1 out", out_port_o, 8'h00);

    // R10 deposit / examine sweep, R7 read of 0x3F
    for (int a = 0; a < 63; a++) poke(6'(a), 8'((a * 37 + 5) & 255));
    for (int a = 0; a < 63; a++) begin
      peek(6'(a), v);
      chk("R10 examine", v, 8'((a * 37 + 5) & 255));
    end
    in_port_i = 8'hA5;
    peek(6'h3F, v);
    chk("R7 panel read 3F", v, 8'hA5);
    poke(6'h3F, 8'h5C);
    chk("R5 panel write 3F drives out", out_port_o, 8'h5C);

    // R1 memory kept over reset
    do_reset();
    peek(6'd10, v);
    chk("R1 memory kept", v, 8'((10 * 37 + 5) & 255));

    // R3 NOR sweep: NOR 21; NOR 22; STA 23; JCC 3
    poke(6'd0, 8'h21); poke(6'd1, 8'h22); poke(6'd2, 8'hA3); poke(6'd3, 8'hC3);
    for (int a = 0; a < 256; a += 51) begin
      for (int b = 0; b < 256; b += 17) begin
        poke(6'h21, ~8'(a)); poke(6'h22, 8'(b));
        run_prog(30);
        peek(6'h23, v);
        chk("R3 nor", v, ~(8'(a) | 8'(b)));
        chk("R3 acc", acc_o, ~(8'(a) | 8'(b)));
        chk("R6 loop pc", {2'b0, pc_o}, 8'h03);
      end
    end

    // R4/R5/R6 ADD sweep: NOR 21; ADD 22; STA 23; STA 3F; JCC 6; STA 24; JCC 6
    poke(6'd0, 8'h21); poke(6'd1, 8'h62); poke(6'd2, 8'hA3); poke(6'd3, 8'hBF);
    poke(6'd4, 8'hC6); poke(6'd5, 8'hA4); poke(6'd6, 8'hC6);
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 257; b += 16) begin
        s = 9'(a) + 9'(b > 255 ? 255 : b);
        poke(6'h21, ~8'(a)); poke(6'h22, 8'(b > 255 ? 255 : b));
        poke(6'h24, ~s[7:0]);
        run_prog(40);
        peek(6'h23, v);
        chk("R4 sum", v, s[7:0]);
        chk("R5 out", out_port_o, s[7:0]);
        peek(6'h24, v);
        chk("R6 carry branch", v, s[8] ? s[7:0] : ~s[7:0]);
        chk("R6 carry cleared", {7'b0, carry_o}, 8'h00);
        chk("R6 pc", {2'b0, pc_o}, 8'h06);
      end
    end

    // R7 input port as operand: NOR 3F; STA 23; STA 3F; JCC 3
    poke(6'd0, 8'h3F); poke(6'd1, 8'hA3); poke(6'd2, 8'hBF); poke(6'd3, 8'hC3);
    for (int i = 0; i < 256; i += 37) begin
      in_port_i = 8'(i);
      run_prog(30);
      peek(6'h23, v);
      chk("R7 operand 3F", v, ~8'(i));
      chk("R7 out", out_port_o, ~8'(i));
    end

    // R8 wrap and R2 timing: every cell holds NOR 3E, input port too
    for (int a = 0; a < 63; a++) poke(6'(a), 8'h3E);
    in_port_i = 8'h3E;
    do_reset();
    run_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R2 pc after 1 edge", {2'b0, pc_o}, 8'h00);
    @(posedge clk_i); #1;
    chk("R2 pc after 2 edges", {2'b0, pc_o}, 8'h01);
    repeat (188) @(posedge clk_i);
    #1 chk("R8 pc at 63", {2'b0, pc_o}, 8'h3F);
    @(posedge clk_i); #1;
    chk("R8 pc wrapped", {2'b0, pc_o}, 8'h00);

    // R9 stop holds state
    repeat (7) @(posedge clk_i);
    @(negedge clk_i);
    run_i = 1'b0;
    repeat (4) @(posedge clk_i);
    #1 p0 = {2'b0, pc_o}; p1 = acc_o;
    repeat (12) @(posedge clk_i);
    #1 chk("R9 pc held", {2'b0, pc_o}, p0);
    chk("R9 acc held", acc_o, p1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule